// File: doc/BRIEF.md
# Serial Third-One Detector

This block is a small clocked state machine that consumes a serial bit stream, one bit on each clock edge where the valid strobe is high, and emits one output bit for every accepted input bit. In the normal case the output is the complement of the input bit: a 0 produces a 1, and a 1 produces a 0. The exception is a 1 that completes a run of three consecutive 1s. That bit produces a 1, and the run count then restarts, so the next 1 counts as the first of a fresh run.

The machine keeps the number of consecutive 1s seen so far (zero, one or two) in a two-bit state register. A 0 on the input clears the count. The output is registered and appears one clock after the input bit is accepted. Clock edges where the valid strobe is low leave both the count and the output unchanged, so a stream with gaps behaves the same as the same bits delivered back to back. The reset is synchronous and active-high.

Top module: `third_one_fsm`

## Requirements
- R1: While reset is high at a clock edge, the output becomes 0 and the run count becomes zero. The next two accepted 1s after reset therefore each produce 0.
- R2: An accepted 0 input produces output 1.
- R3: An accepted 1 that is the first or second consecutive 1 of a run produces output 0.
- R4: An accepted 1 that is the third consecutive 1 produces output 1.
- R5: After a third consecutive 1, the count restarts. Further 1s produce 0, 0, 1 again, and the pattern repeats every three 1s.
- R6: An accepted 0 clears the run count, so a 1 that follows it is again the first of a run.
- R7: On a clock edge where the valid strobe is low, the output holds its value and the run count is unchanged, whatever the data input is.
- R8: The output for an input bit appears after the clock edge that accepts that bit. Before that edge, the output still shows the result of the previous accepted bit.
- R9: A reset in the middle of a run discards the partial count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | High when din is to be accepted on this edge |
| dout | output | 1 | Registered result bit for the last accepted input |

## Verification
The bench targets runs of exactly two 1s followed by a 0. A design that failed to clear the count on a 0 would wrongly give 1 on the first 1 that follows. It also sends long runs of 1s: a design that failed to restart the count after the third 1 would flag every 1 after it instead of every third. Strobe gaps inside a run catch a design that counts on edges where the valid strobe is low, because it would move the position of the third 1. A reset partway through a run catches a design that keeps the partial count. The bench also samples the output before each accepting edge, which exposes any output that is combinational rather than registered.

// File: rtl/third_one_pkg.sv
package third_one_pkg;

    // Run count of consecutive ones; the value 2'b11 is never entered.
    typedef enum logic [1:0] {
        CNT_ZERO    = 2'b00,
        CNT_ONE     = 2'b01,
        CNT_TWO     = 2'b10,
        CNT_ILLEGAL = 2'b11
    } ones_cnt_e;

    typedef struct packed {
        ones_cnt_e cnt;
        logic      res;
    } step_t;

    localparam logic RESET_OUT = 1'b0;

    // One accepted bit: new count and result bit.
    function automatic step_t advance(input ones_cnt_e cur, input logic sbit);
        step_t s;
        if (!sbit) begin
            s.cnt = CNT_ZERO;
            s.res = 1'b1;
        end else begin
            unique case (cur)
                CNT_ZERO: begin s.cnt = CNT_ONE;  s.res = 1'b0; end
                CNT_ONE:  begin s.cnt = CNT_TWO;  s.res = 1'b0; end
                CNT_TWO:  begin s.cnt = CNT_ZERO; s.res = 1'b1; end
                default:  begin s.cnt = CNT_ZERO; s.res = 1'b0; end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/third_one_next.sv
module third_one_next
    import third_one_pkg::*;
(
    input  ones_cnt_e cnt_cur,
    input  logic      sbit,
    output step_t     nxt
);
    always_comb nxt = advance(cnt_cur, sbit);
endmodule

// File: rtl/third_one_regs.sv
module third_one_regs
    import third_one_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  step_t     nxt,
    output ones_cnt_e cnt_q,
    output logic      res_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
            res_q <= RESET_OUT;
        end else if (load) begin
            cnt_q <= nxt.cnt;
            res_q <= nxt.res;
        end
    end
endmodule

// File: rtl/third_one_fsm.sv
module third_one_fsm
    import third_one_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic din_vld,
    output logic dout
);
    ones_cnt_e run_q;
    step_t     step_nxt;

    third_one_next u_next (
        .cnt_cur (run_q),
        .sbit    (din),
        .nxt     (step_nxt)
    );

    third_one_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .load  (din_vld),
        .nxt   (step_nxt),
        .cnt_q (run_q),
        .res_q (dout)
    );
endmodule

// File: rtl/third_one_chk.sv
module third_one_chk (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       din_vld,
    input logic       dout,
    input logic [1:0] run_q
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (run_q == 2'b00) && !dout);

    assert_zero_gives_one_R2: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !din) |=> dout);

    assert_early_one_low_R3: assert property (@(posedge clk) disable iff (rst)
        (din_vld && din && run_q != 2'b10) |=> !dout);

    assert_third_one_high_R4: assert property (@(posedge clk) disable iff (rst)
        (din_vld && din && run_q == 2'b10) |=> dout);

    assert_restart_after_third_R5: assert property (@(posedge clk) disable iff (rst)
        (din_vld && din && run_q == 2'b10) |=> (run_q == 2'b00));

    assert_zero_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !din) |=> (run_q == 2'b00));

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> $stable(dout) && $stable(run_q));

    assert_legal_count_R5: assert property (@(posedge clk) disable iff (rst)
        run_q != 2'b11);
endmodule

bind third_one_fsm third_one_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .din_vld (din_vld),
    .dout    (dout),
    .run_q   (run_q)
);

// File: tb/sim_third_one_fsm.sv
module sim_third_one_fsm;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic din_vld = 1'b0;
    logic dout;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    logic ref_out = 1'b0;
    logic after_third = 1'b0;

    third_one_fsm u0 (.clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .dout(dout));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive one bit, check latency before the edge and the result after it.
    task automatic step(input logic b, input logic v);
        string tag;
        @(negedge clk);
        din = b; din_vld = v;
        #1 check("R8", dout, ref_out);
        if (!v) tag = "R7";
        else if (!b) tag = (ref_cnt > 0) ? "R6" : "R2";
        else if (ref_cnt == 2) tag = "R4";
        else if (after_third) tag = "R5";
        else tag = "R3";
        if (v) begin
            if (!b) begin ref_out = 1'b1; ref_cnt = 0; after_third = 1'b0; end
            else if (ref_cnt == 2) begin ref_out = 1'b1; ref_cnt = 0; after_third = 1'b1; end
            else begin ref_out = 1'b0; ref_cnt++; end
        end
        @(posedge clk);
        #1 check(tag, dout, ref_out);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; din_vld = 1'b0;
        @(posedge clk);
        #1;
        ref_out = 1'b0; ref_cnt = 0; after_third = 1'b0;
        check("R1", dout, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        do_reset();
        // R1: two ones right after reset are first and second of a run
        step(1, 1); step(1, 1); step(1, 1);
        // R2: plain zeros
        step(0, 1); step(0, 1);
        // R5: long run of ones, every third flagged
        for (int i = 0; i < 9; i++) step(1, 1);
        // R6: two ones, a zero, then a new run
        step(1, 1); step(1, 1); step(0, 1); step(1, 1); step(1, 1); step(1, 1);
        // R7: strobe gaps inside a run with toggling data
        step(1, 1); step(1, 0); step(0, 0); step(1, 1); step(0, 0); step(1, 1);
        // R9: reset mid-run discards the count
        step(1, 1); step(1, 1);
        do_reset();
        step(1, 1); step(1, 1); step(1, 1);
        // Pseudo-random stream
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] | lfsr[3], lfsr[5] | lfsr[7]);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule